// File: doc/BRIEF.md
# Interleaved Dual-Bank Flash Reader

This block turns read requests from a 32-bit system bus into reads of a flash array that is split into two banks, each with its own synchronous read port. Even word addresses live in one bank and odd word addresses in the other. The bus asks for words one at a time, and the block returns each word with a single-cycle valid pulse.

The flash can run with no wait state or with one wait state, chosen by a plain configuration pin. With no wait state each accepted address returns its word on the next cycle. With one wait state a bank needs its row held across two clock edges. A random access therefore costs one extra cycle. While a word is being waited for or returned, the block starts reading the next word address in the other bank. A burst of consecutive addresses then streams one word per clock after the first. A gap in the burst or a jump in address throws the speculative read away.

The request side is a valid/ready channel. An address transfers in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is dropped only in the wait cycle of a one-wait-state miss. The master holds `req_valid` and `req_addr` steady until the transfer happens. The response side has no back-pressure: `rsp_valid` is the bus ready, `rsp_data` is meaningful only while it is high, and the master must take the word in that cycle. `cfg_zero_wait` may change only in a cycle where no response is outstanding and no request is presented.

Top module: `ilvf_reader`

## Requirements
- R1: The lowest bit of the word address selects the bank (0: bank 0, 1: bank 1). The remaining upper bits are the row. That row is on the selected bank's row port in the cycle the address is accepted.
- R2: With `cfg_zero_wait` = 1, every accepted address gets `rsp_valid` on the next cycle, addresses can be accepted every cycle, and no speculative read stays armed.
- R3: With `cfg_zero_wait` = 0, an address that is not a prefetch hit gets `rsp_valid` two cycles after acceptance, and `rsp_valid` is low in the cycle between.
- R4: With `cfg_zero_wait` = 0, an address equal to the previous accepted address plus one, accepted in the response cycle of that previous address, returns on the next cycle, so a burst streams one word per clock.
- R5: With `cfg_zero_wait` = 0, a bank's row port holds the same row across the two clock edges before that bank's word is returned. The read of the next address is started on the other bank while the current word is outstanding.
- R6: A cycle with `req_ready` high and `req_valid` low, or an accepted address that is not the prefetched one, discards the speculative read, so the next access pays the R3 latency.
- R7: `req_ready` is low only in the single wait cycle that follows an R3 access.
- R8: After reset `rsp_valid` is low, `req_ready` is high and no speculative read is armed; `cfg_zero_wait` = 0 selects the one-wait-state mode.
- R9: Sequential order wraps: the highest word address followed by address 0 counts as a sequential burst under R4.
- R10: While `rsp_valid` is high, `rsp_data` is the word stored at the accepted address, taken from the bank and row given by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_zero_wait | input | 1 | 1: zero-wait-state mode, 0: one-wait-state mode |
| req_valid | input | 1 | Read address presented |
| req_ready | output | 1 | Address accepted this cycle when valid is high |
| req_addr | input | ADDR_W | Word address |
| rsp_valid | output | 1 | Read data valid (bus ready) |
| rsp_data | output | DATA_W | Read data |
| bank0_row | output | ADDR_W-1 | Row address to the even-word bank |
| bank0_rdata | input | DATA_W | Registered read data from the even-word bank |
| bank1_row | output | ADDR_W-1 | Row address to the odd-word bank |
| bank1_rdata | input | DATA_W | Registered read data from the odd-word bank |

## Verification
On every cycle, the assertions hold the response timing of each access kind to its latency: zero-wait, miss and prefetch hit. They also check that the ready gap appears only after a miss, that a burst break or zero-wait mode disarms the prefetch, that the two bank ports are never claimed together, and that a returned bank's row was stable over the two preceding edges. The data itself can be shown only by the bench. Its bank models return a poison word whenever a row was not held for two edges in one-wait mode. Only the bench's sweeps can show the other end-to-end properties: every start address including the wrap, idle gaps, backward jumps, and the switch between modes.

// File: rtl/ilvf_pkg.sv
package ilvf_pkg;

  localparam int NUM_BANKS = 2;

  // How an accepted address is served.
  typedef enum logic [1:0] {
    FK_IDLE   = 2'd0,  // nothing accepted this cycle
    FK_DIRECT = 2'd1,  // zero-wait read, data next cycle
    FK_MISS   = 2'd2,  // one-wait read, data after a wait cycle
    FK_HIT    = 2'd3   // prefetched word, data next cycle
  } fetch_kind_e;

endpackage

// File: rtl/ilvf_addr_split.sv
module ilvf_addr_split #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank,
  output logic [ADDR_W-2:0] row
);
  // Consecutive words alternate banks: bit 0 picks the bank, the rest is the row.
  assign bank = addr[0];
  assign row  = addr[ADDR_W-1:1];
endmodule

// File: rtl/ilvf_xfer_ctl.sv
module ilvf_xfer_ctl
  import ilvf_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_wait,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hit,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              wait_q,
  output logic [ADDR_W-1:0] cur_addr_q,
  output fetch_kind_e       kind
);
  logic pend_q;
  logic acc;

  assign rsp_valid = pend_q & ~wait_q;
  assign req_ready = rst_n & ~(pend_q & wait_q);
  assign acc       = req_valid & req_ready;

  always_comb begin
    if (!acc)          kind = FK_IDLE;
    else if (!one_wait) kind = FK_DIRECT;
    else if (hit)      kind = FK_HIT;
    else               kind = FK_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      wait_q     <= 1'b0;
      cur_addr_q <= '0;
    end else if (acc) begin
      pend_q     <= 1'b1;
      wait_q     <= (kind == FK_MISS);
      cur_addr_q <= req_addr;
    end else if (wait_q) begin
      wait_q <= 1'b0;
    end else if (rsp_valid) begin
      pend_q <= 1'b0;
    end
  end

  p_direct_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_DIRECT) |=> rsp_valid);
  p_miss_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_MISS) |=> !rsp_valid);
  p_miss_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kind == FK_MISS, 2) |-> rsp_valid);
  p_hit_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_HIT) |=> rsp_valid);
  p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $past(kind == FK_MISS));

endmodule

// File: rtl/ilvf_prefetch_trk.sv
module ilvf_prefetch_trk #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_wait,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wait_q,
  input  logic [ADDR_W-1:0] cur_addr_q,
  output logic              hit,
  output logic              pf_go,
  output logic [ADDR_W-1:0] pf_go_addr
);
  logic              pf_valid_q;
  logic [ADDR_W-1:0] pf_addr_q;
  logic              acc;

  assign acc = req_valid & req_ready;

  // A hit needs the armed address and the request in the very next slot.
  assign hit = acc & one_wait & pf_valid_q & (req_addr == pf_addr_q);

  // Launch the next word's read one cycle after the current word's read began:
  // in the wait cycle of a miss, or in the accept cycle of a hit.
  assign pf_go      = one_wait & (wait_q | hit);
  assign pf_go_addr = wait_q ? (cur_addr_q + ADDR_W'(1)) : (req_addr + ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid_q <= 1'b0;
      pf_addr_q  <= '0;
    end else if (!one_wait) begin
      pf_valid_q <= 1'b0;
    end else if (pf_go) begin
      pf_valid_q <= 1'b1;
      pf_addr_q  <= pf_go_addr;
    end else if (acc || (req_ready && !req_valid)) begin
      pf_valid_q <= 1'b0;
    end
  end

  p_break_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !pf_valid_q);
  p_zero_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !one_wait |=> !pf_valid_q);
  p_hit_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(pf_go));

endmodule

// File: rtl/ilvf_bank_port.sv
module ilvf_bank_port #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dem_en,
  input  logic [ROW_W-1:0] dem_row,
  input  logic             pf_en,
  input  logic [ROW_W-1:0] pf_row,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;

  // Demand wins, then prefetch, otherwise the row stays put so it settles.
  always_comb begin
    if (dem_en)     row = dem_row;
    else if (pf_en) row = pf_row;
    else            row = row_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row;
  end

  p_port_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dem_en && pf_en));

endmodule

// File: rtl/ilvf_reader.sv
module ilvf_reader
  import ilvf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_zero_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-2:0] bank0_row,
  input  logic [DATA_W-1:0] bank0_rdata,
  output logic [ADDR_W-2:0] bank1_row,
  input  logic [DATA_W-1:0] bank1_rdata
);
  localparam int ROW_W = ADDR_W - 1;

  logic              one_wait;
  logic              hit;
  logic              wait_q;
  logic [ADDR_W-1:0] cur_addr_q;
  fetch_kind_e       kind;
  logic              pf_go;
  logic [ADDR_W-1:0] pf_go_addr;
  logic              req_bank, pf_bank, cur_bank;
  logic [ROW_W-1:0]  req_row, pf_row, cur_row;
  logic [ROW_W-1:0]  rows  [NUM_BANKS];
  logic [DATA_W-1:0] rdata [NUM_BANKS];

  assign one_wait = ~cfg_zero_wait;

  ilvf_addr_split #(.ADDR_W(ADDR_W)) u_split_req (
    .addr(req_addr), .bank(req_bank), .row(req_row));
  ilvf_addr_split #(.ADDR_W(ADDR_W)) u_split_pf (
    .addr(pf_go_addr), .bank(pf_bank), .row(pf_row));
  ilvf_addr_split #(.ADDR_W(ADDR_W)) u_split_cur (
    .addr(cur_addr_q), .bank(cur_bank), .row(cur_row));

  ilvf_xfer_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .one_wait(one_wait),
    .req_valid(req_valid), .req_addr(req_addr), .hit(hit),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .wait_q(wait_q),
    .cur_addr_q(cur_addr_q), .kind(kind));

  ilvf_prefetch_trk #(.ADDR_W(ADDR_W)) u_pf (
    .clk(clk), .rst_n(rst_n), .one_wait(one_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .wait_q(wait_q), .cur_addr_q(cur_addr_q),
    .hit(hit), .pf_go(pf_go), .pf_go_addr(pf_go_addr));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic dem_en, pf_en;
    assign dem_en = ((kind == FK_MISS) || (kind == FK_DIRECT)) && (req_bank == 1'(k));
    assign pf_en  = pf_go && (pf_bank == 1'(k));

    ilvf_bank_port #(.ROW_W(ROW_W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .dem_en(dem_en), .dem_row(req_row),
      .pf_en(pf_en), .pf_row(pf_row),
      .row(rows[k]));

    p_row_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cur_bank == 1'(k) && one_wait && $past(one_wait) && $past(one_wait, 2))
        |-> ($past(rows[k]) == $past(rows[k], 2) && $past(rows[k]) == cur_row));
  end

  assign bank0_row = rows[0];
  assign bank1_row = rows[1];
  assign rdata[0]  = bank0_rdata;
  assign rdata[1]  = bank1_rdata;
  assign rsp_data  = rdata[cur_bank];

endmodule

// File: tb/ilvf_reader_bench.sv
module ilvf_reader_bench;
  localparam int AW    = 5;
  localparam int RW    = AW - 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] POISON = 32'hDEAD_BEEF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_zero_wait = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic [RW-1:0] bank0_row, bank1_row;
  logic [31:0]   bank0_rdata, bank1_rdata;

  ilvf_reader #(.ADDR_W(AW), .DATA_W(32)) u_ilvf_reader (
    .clk(clk), .rst_n(rst_n), .cfg_zero_wait(cfg_zero_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bank0_row(bank0_row), .bank0_rdata(bank0_rdata),
    .bank1_row(bank1_row), .bank1_rdata(bank1_rdata));

  always #5 clk = ~clk;

  function automatic logic [31:0] word_of(input int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Bank models: one-cycle read; in one-wait mode a row must be held two edges.
  logic [RW-1:0] b0_prev = '0, b1_prev = '0;
  always @(posedge clk) begin
    bank0_rdata <= (cfg_zero_wait || bank0_row == b0_prev) ? word_of(int'(bank0_row) * 2) : POISON;
    bank1_rdata <= (cfg_zero_wait || bank1_row == b1_prev) ? word_of(int'(bank1_row) * 2 + 1) : POISON;
    b0_prev <= bank0_row;
    b1_prev <= bank1_row;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Scoreboard of expected responses.
  int    exp_addr [1024];
  int    exp_cyc  [1024];
  string exp_tag  [1024];
  int    wp = 0, rp = 0;
  int    wait_cyc = -1;
  bit    have_prev = 1'b0;
  int    prev_c = 0, prev_a = 0, prev_lat = 0;
  bit    mon_on = 1'b0;

  task automatic push(input int a, input int c);
    bit seq;
    int lat;
    seq = !cfg_zero_wait && have_prev && (c == prev_c + prev_lat) && (a == (prev_a + 1) % DEPTH);
    lat = (cfg_zero_wait || seq) ? 1 : 2;
    exp_addr[wp] = a;
    exp_cyc[wp]  = c + lat;
    if (cfg_zero_wait)  exp_tag[wp] = "R2 zero-wait timing";
    else if (!seq)      exp_tag[wp] = "R3 miss timing";
    else if (a == 0)    exp_tag[wp] = "R9 wrap burst timing";
    else                exp_tag[wp] = "R4 burst timing";
    wp++;
    if (lat == 2) wait_cyc = c + 1;
    have_prev = 1'b1; prev_c = c; prev_a = a; prev_lat = lat;
  endtask

  task automatic send(input int a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a % DEPTH);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    push(a % DEPTH, cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor, sampled mid-cycle after the driver has settled.
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      check(req_ready == (cyc != wait_cyc), "R7 ready only drops in miss wait",
            32'(req_ready), 32'(cyc != wait_cyc));
      if (req_valid && req_ready) begin
        if (req_addr[0])
          check(bank1_row == req_addr[AW-1:1], "R1 odd word row on bank 1",
                32'(bank1_row), 32'(req_addr[AW-1:1]));
        else
          check(bank0_row == req_addr[AW-1:1], "R1 even word row on bank 0",
                32'(bank0_row), 32'(req_addr[AW-1:1]));
      end
      if (rsp_valid) begin
        if (rp >= wp) begin
          check(1'b0, "R10 unexpected response", 32'(rsp_valid), 32'd0);
        end else begin
          check(exp_cyc[rp] == cyc, exp_tag[rp], 32'(cyc), 32'(exp_cyc[rp]));
          check(rsp_data == word_of(exp_addr[rp]), "R10 response data (R5 settled row)",
                rsp_data, word_of(exp_addr[rp]));
          rp++;
        end
      end else if (rp < wp && exp_cyc[rp] <= cyc) begin
        check(1'b0, exp_tag[rp], 32'(cyc), 32'(exp_cyc[rp]));
        rp++;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R8: reset state with the default one-wait mode.
    check(rsp_valid == 1'b0, "R8 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R8 req_ready high after reset", 32'(req_ready), 32'd1);
    mon_on = 1'b1;

    // R8: the very first access is a miss even though nothing precedes it.
    send(7); idle(3);

    // R3 R4 R9: four-word bursts from every start, wrapping past the top.
    for (int s = 0; s < DEPTH; s++) begin
      for (int k = 0; k < 4; k++) send(s + k);
      idle(2);
    end

    // R6: an idle slot inside a burst breaks it.
    for (int s = 0; s < DEPTH; s++) begin
      send(s); idle(1); send(s + 1); send(s + 2); idle(2);
    end

    // R6: jumps, backward steps and same-bank repeats.
    for (int s = 0; s < DEPTH; s++) begin
      send(s); send(s + 2); send(s + 1); send(s + 2); send(s + 5); send(s + 5); send(s + 6);
      idle(2);
    end

    // R2: zero-wait mode, sequential and strided, back to back.
    cfg_zero_wait = 1'b1;
    idle(2);
    for (int s = 0; s < DEPTH; s++) begin
      send(s); send(s + 1); send(s + 7); send(s + 7);
    end
    idle(3);

    // R4 R9: back to one-wait mode, a long burst that wraps twice.
    cfg_zero_wait = 1'b0;
    idle(2);
    for (int k = 0; k < 2 * DEPTH + 3; k++) send(5 + k);
    idle(6);

    check(rp == wp, "R10 every accepted address answered", 32'(rp), 32'(wp));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule